// File: doc/BRIEF.md
# Byte-Controlled Registered Bus Transceiver

This block links two 16-bit buses, A and B. It does not invert data, and data can flow in either direction. Each side has an 8-bit-per-group holding register. A register loads from its own bus on the rising edge of a dedicated capture strobe. The word is cut into two independent byte groups. Each group has an active-low output enable, a direction bit, a capture strobe for each register and a path select for each direction.

Within a group, the direction bit chooses the port to drive. The path select chooses what that port carries: the live value from the opposite bus, or the contents of the opposite side's register. Every three-state pin is split into three signals: an input value, an output value and a per-group drive enable. Tying the controls of the two groups together gives full 16-bit operation.

The registers keep loading while the outputs are isolated. A strobe in stored mode also shows the new value on the driven port at once, so one strobe both loads and outputs.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An active-low asynchronous reset clears all four 8-bit registers. After reset, every stored-mode path outputs 0x00.
- R2: On a rising edge of cap_a_i[g], the A register of group g loads a_i bits [8g+7:8g]. On a rising edge of cap_b_i[g], the B register of group g loads b_i bits [8g+7:8g]. A strobe for one register leaves the other register unchanged.
- R3: Register loading works the same for every setting of oe_ni and dir_i, isolation included.
- R4: While oe_ni[g] is 1, both a_oe_o[g] and b_oe_o[g] are 0. On any byte whose drive enable is 0, the matching a_o or b_o bits read 0x00.
- R5: While oe_ni[g]=0, dir_i[g]=1 and sel_ab_i[g]=0, b_oe_o[g]=1 and a_oe_o[g]=0. The B byte then equals the live A byte, with no clock between them.
- R6: While oe_ni[g]=0, dir_i[g]=1 and sel_ab_i[g]=1, the B byte equals the A register of group g.
- R7: While oe_ni[g]=0, dir_i[g]=0 and sel_ba_i[g]=0, a_oe_o[g]=1 and b_oe_o[g]=0. The A byte then equals the live B byte, with no clock between them.
- R8: While oe_ni[g]=0, dir_i[g]=0 and sel_ba_i[g]=1, the A byte equals the B register of group g.
- R9: The controls and strobes of one group have no effect on the other group's outputs, enables or registers.
- R10: In stored mode, a strobe into the selected register makes the newly loaded byte appear on the driven port right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low; clears all registers |
| oe_ni | input | 2 | Per-group output enable, active low |
| dir_i | input | 2 | Per-group direction: 1 drives B, 0 drives A |
| cap_a_i | input | 2 | Per-group rising-edge strobe that loads the A register from a_i |
| cap_b_i | input | 2 | Per-group rising-edge strobe that loads the B register from b_i |
| sel_ab_i | input | 2 | Per-group source for the B port: 0 live A, 1 A register |
| sel_ba_i | input | 2 | Per-group source for the A port: 0 live B, 1 B register |
| a_i | input | 16 | Value seen on the A bus pins |
| a_o | output | 16 | Value driven onto the A bus pins |
| a_oe_o | output | 2 | Per-group drive enable for a_o |
| b_i | input | 16 | Value seen on the B bus pins |
| b_o | output | 16 | Value driven onto the B bus pins |
| b_oe_o | output | 2 | Per-group drive enable for b_o |

## Verification
The bench steps through all 256 joint control settings of the two groups with several data patterns, and issues a different mix of strobes at each step. A swapped select polarity would put register data on a live path. A shared enable would let one group's isolation silence the other group. After each strobe the bench checks the driven port. A design that only updated stored outputs on a later cycle, or that blocked loading while isolated, would show a stale byte. A design whose strobe loaded the wrong side's register would show the wrong byte. Isolated ports are checked for zero enables and zero data, and registers are checked after both power-on reset and a reset in the middle of the run.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
  } grp_ctl_t;

  typedef enum logic [1:0] {
    ROUTE_OFF    = 2'd0,
    ROUTE_TO_B   = 2'd1,
    ROUTE_TO_A   = 2'd2
  } route_t;
endpackage

// File: rtl/bxr_reg.sv
module bxr_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (q_o == $past(d_i))) else $error("capture mismatch"); // R2
endmodule

// File: rtl/bxr_route.sv
module bxr_route
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  grp_ctl_t     ctl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] ra_i,
  input  logic [W-1:0] rb_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         a_oe_o,
  output logic         b_oe_o
);
  route_t route;

  always_comb begin
    if (ctl_i.oe_n)    route = ROUTE_OFF;
    else if (ctl_i.dir) route = ROUTE_TO_B;
    else               route = ROUTE_TO_A;
  end

  always_comb begin
    a_o    = '0;
    b_o    = '0;
    a_oe_o = 1'b0;
    b_oe_o = 1'b0;
    unique case (route)
      ROUTE_TO_B: begin
        b_oe_o = 1'b1;
        b_o    = ctl_i.sel_ab ? ra_i : a_i;
      end
      ROUTE_TO_A: begin
        a_oe_o = 1'b1;
        a_o    = ctl_i.sel_ba ? rb_i : b_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    AST_ONE_DRIVER: assert (!(a_oe_o && b_oe_o)); // R5
    AST_ISOLATE: assert (!ctl_i.oe_n || (!a_oe_o && !b_oe_o)); // R4
    AST_QUIET_A: assert (a_oe_o || a_o == '0); // R4
    AST_QUIET_B: assert (b_oe_o || b_o == '0); // R4
    AST_LIVE_AB: assert (!(b_oe_o && !ctl_i.sel_ab) || b_o == a_i); // R5
    AST_STORED_AB: assert (!(b_oe_o && ctl_i.sel_ab) || b_o == ra_i); // R6
    AST_LIVE_BA: assert (!(a_oe_o && !ctl_i.sel_ba) || a_o == b_i); // R7
    AST_STORED_BA: assert (!(a_oe_o && ctl_i.sel_ba) || a_o == rb_i); // R8
  end
endmodule

// File: rtl/bxr_group.sv
module bxr_group
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_ni,
  input  grp_ctl_t     ctl_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         a_oe_o,
  output logic         b_oe_o
);
  logic [W-1:0] ra_q, rb_q;

  // loading ignores oe/dir: the port input is always sampled
  bxr_reg #(.W(W)) u_reg_a (
    .clk_i (cap_a_i),
    .rst_ni(rst_ni),
    .d_i   (a_i),
    .q_o   (ra_q)
  );

  bxr_reg #(.W(W)) u_reg_b (
    .clk_i (cap_b_i),
    .rst_ni(rst_ni),
    .d_i   (b_i),
    .q_o   (rb_q)
  );

  bxr_route #(.W(W)) u_route (
    .ctl_i (ctl_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .ra_i  (ra_q),
    .rb_i  (rb_q),
    .a_o   (a_o),
    .b_o   (b_o),
    .a_oe_o(a_oe_o),
    .b_oe_o(b_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter  int GROUPS  = 2,
  parameter  int GROUP_W = 8,
  localparam int DATA_W  = GROUPS * GROUP_W
) (
  input  logic              rst_ni,
  input  logic [GROUPS-1:0] oe_ni,
  input  logic [GROUPS-1:0] dir_i,
  input  logic [GROUPS-1:0] cap_a_i,
  input  logic [GROUPS-1:0] cap_b_i,
  input  logic [GROUPS-1:0] sel_ab_i,
  input  logic [GROUPS-1:0] sel_ba_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic [GROUPS-1:0] a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic [GROUPS-1:0] b_oe_o
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    grp_ctl_t ctl;
    assign ctl = '{oe_n: oe_ni[g], dir: dir_i[g], sel_ab: sel_ab_i[g], sel_ba: sel_ba_i[g]};

    bxr_group #(.W(GROUP_W)) u_grp (
      .rst_ni (rst_ni),
      .ctl_i  (ctl),
      .cap_a_i(cap_a_i[g]),
      .cap_b_i(cap_b_i[g]),
      .a_i    (a_i[g*GROUP_W +: GROUP_W]),
      .b_i    (b_i[g*GROUP_W +: GROUP_W]),
      .a_o    (a_o[g*GROUP_W +: GROUP_W]),
      .b_o    (b_o[g*GROUP_W +: GROUP_W]),
      .a_oe_o (a_oe_o[g]),
      .b_oe_o (b_oe_o[g])
    );
  end
endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  oe_ni, dir_i, cap_a_i, cap_b_i, sel_ab_i, sel_ba_i;
  logic [15:0] a_i, b_i, a_o, b_o;
  logic [1:0]  a_oe_o, b_oe_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] ra [2];
  logic [7:0] rb [2];

  always #5 clk = ~clk;

  bus_xcvr_reg u_dut (
    .rst_ni(rst_ni), .oe_ni(oe_ni), .dir_i(dir_i),
    .cap_a_i(cap_a_i), .cap_b_i(cap_b_i),
    .sel_ab_i(sel_ab_i), .sel_ba_i(sel_ba_i),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // packed {a_oe, b_oe, a_byte, b_byte}
  function automatic logic [17:0] exp_grp(int g);
    logic [7:0] ab = a_i[g*8 +: 8];
    logic [7:0] bb = b_i[g*8 +: 8];
    if (oe_ni[g]) return 18'd0;
    if (dir_i[g]) return {2'b01, 8'h00, sel_ab_i[g] ? ra[g] : ab};
    return {2'b10, sel_ba_i[g] ? rb[g] : bb, 8'h00};
  endfunction

  function automatic logic [17:0] act_grp(int g);
    return {a_oe_o[g], b_oe_o[g], a_o[g*8 +: 8], b_o[g*8 +: 8]};
  endfunction

  function automatic string mode_tag(int g, bit after_cap);
    if (oe_ni[g]) return after_cap ? "R3" : "R4";
    if (dir_i[g]) return sel_ab_i[g] ? (after_cap ? "R10" : "R6") : "R5";
    return sel_ba_i[g] ? (after_cap ? "R10" : "R8") : "R7";
  endfunction

  task automatic check_all(bit after_cap);
    for (int g = 0; g < 2; g++) chk(mode_tag(g, after_cap), 32'(act_grp(g)), 32'(exp_grp(g)));
  endtask

  task automatic strobe(logic [1:0] ma, logic [1:0] mb);
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      if (ma[g]) ra[g] = a_i[g*8 +: 8];
      if (mb[g]) rb[g] = b_i[g*8 +: 8];
    end
    cap_a_i = ma;
    cap_b_i = mb;
    #2;
  endtask

  task automatic release_strobe();
    #2;
    cap_a_i = 2'b00;
    cap_b_i = 2'b00;
  endtask

  task automatic set_ctl(logic [3:0] c0, logic [3:0] c1);
    oe_ni    = {c1[0], c0[0]};
    dir_i    = {c1[1], c0[1]};
    sel_ab_i = {c1[2], c0[2]};
    sel_ba_i = {c1[3], c0[3]};
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] keep_a;
    logic [7:0] hold;
    rst_ni = 1'b0;
    cap_a_i = 2'b00; cap_b_i = 2'b00;
    a_i = 16'h5a3c; b_i = 16'hc3a5;
    set_ctl(4'b0000, 4'b0000);
    for (int g = 0; g < 2; g++) begin ra[g] = 8'h00; rb[g] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: stored paths read zero after reset
    set_ctl(4'b0110, 4'b0110);
    #2 chk("R1", 32'(b_o), 32'h0000);
    set_ctl(4'b1000, 4'b1000);
    #2 chk("R1", 32'(a_o), 32'h0000);

    // R3: load while isolated, then read both registers back
    set_ctl(4'b0001, 4'b0001);
    a_i = 16'h12ef; b_i = 16'h9a47;
    strobe(2'b11, 2'b11); check_all(1'b1); release_strobe();
    chk("R3", 32'({a_oe_o, b_oe_o}), 32'h0);
    set_ctl(4'b0110, 4'b0110);
    a_i = 16'h0000; b_i = 16'h0000;
    #2 chk("R3", 32'(b_o), 32'h12ef);
    set_ctl(4'b1000, 4'b1000);
    #2 chk("R3", 32'(a_o), 32'h9a47);

    // R2: strobing B leaves A register alone
    set_ctl(4'b0110, 4'b0110);
    b_i = 16'h7777;
    strobe(2'b00, 2'b11); release_strobe();
    #2 chk("R2", 32'(b_o), 32'h12ef);
    set_ctl(4'b1000, 4'b1000);
    #2 chk("R2", 32'(a_o), 32'h7777);

    // R9: group 1 holds stored B->A while group 0 churns
    hold = rb[1];
    set_ctl(4'b0000, 4'b1000);
    for (int k = 0; k < 16; k++) begin
      set_ctl(4'(k), 4'b1000);
      a_i[7:0] = 8'(k * 29);
      b_i[7:0] = 8'(k * 53 + 1);
      strobe(2'b01, 2'b01); release_strobe();
      #1 chk("R9", 32'({a_oe_o[1], b_oe_o[1], a_o[15:8]}), 32'({2'b10, hold}));
    end

    // exhaustive sweep of joint controls with several data patterns
    for (int ctl = 0; ctl < 256; ctl++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        set_ctl(4'(ctl), 4'(ctl >> 4));
        a_i = 16'(ctl * 40503 + p * 4661);
        b_i = ~a_i ^ 16'(p * 257 + ctl);
        #2 check_all(1'b0);
        keep_a = 16'((ctl + p * 3) & 15);
        strobe(keep_a[1:0], keep_a[3:2]);
        check_all(1'b1);
        release_strobe();
      end
    end

    // R1: reset mid-run clears registers
    set_ctl(4'b0110, 4'b0110);
    @(negedge clk);
    rst_ni = 1'b0;
    #2 chk("R1", 32'(b_o), 32'h0000);
    rst_ni = 1'b1;
    set_ctl(4'b1000, 4'b1000);
    #2 chk("R1", 32'(a_o), 32'h0000);

    finish_run();
  end
endmodule